// File: doc/BRIEF.md
# Three-Stage Integer Pipeline with Drain Control

This block is a compact in-order integer core built from three stages. The first stage fetches a 32-bit instruction word and decodes it. The second stage runs the ALU. The third stage commits the result to the register file. A register sits between each pair of stages. The core executes five register-register operations (add, sub, and, or, set-less-than), four register-immediate operations (add, and, or and set-less-than, each with an immediate) and a no-op. A single-entry bypass sends the value held in the last pipeline register straight back to the ALU operands, so dependent instructions can issue back to back without stalling.

A drain input empties the pipeline. While it is high, a no-op takes the place of the fetched word. The program counter holds its value, and neither the instruction store nor the register file is read. Instructions already inside the pipeline still finish. When the input falls, the core resumes at the held address. The data width is a parameter between 4 and 64 bits. The instruction store is a small array that the environment writes through a load port, normally while reset is asserted. Each commit appears on a write-back observation port.

Top module: `tsc_core`

## Requirements
- R1: While reset is low at a clock edge, the program counter becomes 0, the register file clears, and after that edge no write-back is reported.
- R2: In every cycle without drain, the program counter advances by 4. It wraps at the end of the instruction store.
- R3: Opcode 0x00 selects a register-register instruction, with sources in bits [25:21] and [20:16] and the destination in bits [15:11]. Bits [5:0] select the function: add 0x20, sub 0x22, and 0x24, or 0x25, set-less-than 0x2A.
- R4: Opcodes 0x08 (add), 0x0C (and) and 0x0D (or) take the register in [25:21] and the low min(W/2,16) bits of [15:0], sign-extended to W, and write the result to the register in [20:16].
- R5: Set-less-than (function 0x2A) and its immediate form (opcode 0x0A) compare the operands as signed values and write 1 or 0.
- R6: An instruction fetched in cycle t is reported on the write-back port (enable, register, value) in cycle t+2.
- R7: An instruction that reads the destination of the instruction just before it, or of the one two places before it, sees the new value.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 produces no write-back.
- R9: The all-zero word, any undecoded opcode or function, and a register-register word with bits [10:6] nonzero all act as no-ops: no write-back and no register change.
- R10: While drain is high, the program counter holds and a bubble enters the pipeline. Instructions in flight still complete. After release, execution resumes at the held address and no instruction is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drain request: inject no-op, hold program counter |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | IA_W | Instruction store word address |
| imem_wdata | input | 32 | Instruction word to store |
| pc_o | output | IA_W+2 | Current fetch byte address |
| wb_en_o | output | 1 | Write-back commit this cycle |
| wb_addr_o | output | 5 | Register written |
| wb_data_o | output | DATA_W | Value written |

## Verification
On every cycle the assertions check these properties: the program counter holds or steps by one word depending on drain, drain and no-op words put a non-writing entry into the execute register, every execute entry that writes reaches write-back exactly one cycle later, and no commit targets register 0. The arithmetic results, signed comparison, immediate sign extension, and the values carried across bypass distances one and two can only be shown by the bench's programs. The bench compares each commit against a sequential model of the same instruction stream. It does this across repeated drain windows and across program-counter wraparound.

// File: rtl/tsc_pkg.sv
// Shared encodings and decoded-control type for the three-stage core.
// Assumes the fixed 32-bit instruction layout described in the brief.
package tsc_pkg;

    localparam logic [5:0] OPC_RREG = 6'h00;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        alu_op_e           op;
        logic              use_imm;
        logic              wr_en;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic [REG_AW-1:0] dst;
    } dec_ctl_t;

endpackage

// File: rtl/tsc_fetch.sv
// Fetch unit: program counter (kept as a word index) and instruction store.
// Assumes IMEM_DEPTH is a power of two; the counter wraps at the store end.
// While flush is high the counter holds and the store is not read; the
// output word is then all zero, which decodes as a no-op.
module tsc_fetch #(
    parameter int IMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            load_we,
    input  logic [IA_W-1:0] load_addr,
    input  logic [31:0]     load_data,
    output logic [IA_W-1:0] word_idx_o,
    output logic [31:0]     instr_o
);

    logic [IA_W-1:0] word_q;
    logic [31:0]     store [IMEM_DEPTH];
    logic            fetch_en;

    assign fetch_en = !flush;

    // Advance the fetch index one word per cycle unless draining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (fetch_en) begin
            word_q <= word_q + IA_W'(1);
        end
    end

    // Write the instruction store from the load port.
    always_ff @(posedge clk) begin
        if (load_we) begin
            store[load_addr] <= load_data;
        end
    end

    // Read the store only when fetch is enabled; otherwise present a no-op.
    always_comb begin
        if (fetch_en) begin
            instr_o = store[word_q];
        end else begin
            instr_o = '0;
        end
    end

    assign word_idx_o = word_q;

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(word_q));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (word_q == $past(word_q) + IA_W'(1)));

endmodule

// File: rtl/tsc_decode.sv
// Instruction decoder: classifies the word, picks source and destination
// registers, and builds the sign-extended immediate of min(W/2,16) bits.
// Assumes DATA_W is between 4 and 64. Anything it does not recognise is
// decoded as a non-writing entry. A destination of register 0 also clears
// the write enable.
module tsc_decode
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IMM_W = ((DATA_W / 2) < 16) ? (DATA_W / 2) : 16
) (
    input  logic [31:0]       instr,
    output dec_ctl_t          ctl,
    output logic [DATA_W-1:0] imm_o
);

    logic [5:0]        opcode;
    logic [5:0]        funct;
    logic [4:0]        zero_fld;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic              legal;
    logic [REG_AW-1:0] dst_sel;

    assign opcode   = instr[31:26];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign zero_fld = instr[10:6];
    assign funct    = instr[5:0];

    // Sign-extend the low IMM_W bits of the immediate field.
    assign imm_o = {{(DATA_W - IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    // Classify the word and choose the ALU operation and destination.
    always_comb begin
        legal       = 1'b0;
        dst_sel     = f_rt;
        ctl.op      = ALU_ADD;
        ctl.use_imm = 1'b0;
        ctl.src_a   = f_rs;
        ctl.src_b   = f_rt;
        unique case (opcode)
            OPC_RREG: begin
                dst_sel = f_rd;
                if (zero_fld == 5'd0) begin
                    legal = 1'b1;
                    unique case (funct)
                        FN_ADD:  ctl.op = ALU_ADD;
                        FN_SUB:  ctl.op = ALU_SUB;
                        FN_AND:  ctl.op = ALU_AND;
                        FN_OR:   ctl.op = ALU_OR;
                        FN_SLT:  ctl.op = ALU_SLT;
                        default: legal = 1'b0;
                    endcase
                end
            end
            OPC_ADDI: begin
                legal = 1'b1; ctl.use_imm = 1'b1; ctl.op = ALU_ADD;
            end
            OPC_SLTI: begin
                legal = 1'b1; ctl.use_imm = 1'b1; ctl.op = ALU_SLT;
            end
            OPC_ANDI: begin
                legal = 1'b1; ctl.use_imm = 1'b1; ctl.op = ALU_AND;
            end
            OPC_ORI: begin
                legal = 1'b1; ctl.use_imm = 1'b1; ctl.op = ALU_OR;
            end
            default: legal = 1'b0;
        endcase
        ctl.dst   = dst_sel;
        ctl.wr_en = legal && (dst_sel != '0);
    end

endmodule

// File: rtl/tsc_regfile.sv
// Register file with two read ports and one write port.
// Register 0 is hard zero. A write in the same cycle as a read to the same
// register is passed through to the read. A port whose read enable is low
// returns zero.
module tsc_regfile
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NREG = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [REG_AW-1:0] wa,
    input  logic [DATA_W-1:0] wd
);

    logic [DATA_W-1:0] regs [NREG];

    // Clear on reset; afterwards commit writes to any register except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    function automatic logic [DATA_W-1:0] read_port(input logic [REG_AW-1:0] ra);
        logic [DATA_W-1:0] v;
        if (!rd_en || (ra == '0)) begin
            v = '0;
        end else if (we && (wa == ra)) begin
            v = wd;
        end else begin
            v = regs[ra];
        end
        return v;
    endfunction

    // Serve both read ports with write-through.
    always_comb begin
        rd_a = read_port(ra_a);
        rd_b = read_port(ra_b);
    end

endmodule

// File: rtl/tsc_alu.sv
// Integer ALU: add, subtract, and, or, and signed set-less-than.
// Purely combinational. A set-less-than result is 1 or 0, zero-extended.
module tsc_alu
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    logic lt;

    assign lt = $signed(a) < $signed(b);

    // Select the result for the requested operation.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DATA_W - 1){1'b0}}, lt};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/tsc_core.sv
// Three-stage integer core: fetch/decode, execute and write-back, with
// registers between the stages. A bypass sends the write-back register's
// value to the ALU operands. The register file passes same-cycle writes
// through to reads, which covers a distance of two. Drain (flush) puts
// no-ops into the pipeline and holds the program counter.
// Assumes the instruction store is loaded before reset is released.
module tsc_core
    import tsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH),
    localparam int PC_W = IA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              imem_we,
    input  logic [IA_W-1:0]   imem_waddr,
    input  logic [31:0]       imem_wdata,
    output logic [PC_W-1:0]   pc_o,
    output logic              wb_en_o,
    output logic [REG_AW-1:0] wb_addr_o,
    output logic [DATA_W-1:0] wb_data_o
);

    // Fetch/decode stage signals.
    logic [IA_W-1:0]   word_idx;
    logic [31:0]       instr_f;
    dec_ctl_t          ctl_d;
    logic [DATA_W-1:0] imm_d;
    logic [DATA_W-1:0] rs_val_d;
    logic [DATA_W-1:0] rt_val_d;

    // Execute-stage register and signals.
    dec_ctl_t          ex_ctl;
    logic [DATA_W-1:0] ex_a;
    logic [DATA_W-1:0] ex_b;
    logic [DATA_W-1:0] ex_imm;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b_fwd;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_y;

    // Write-back register.
    logic              wb_we;
    logic [REG_AW-1:0] wb_dst;
    logic [DATA_W-1:0] wb_val;

    tsc_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .load_we    (imem_we),
        .load_addr  (imem_waddr),
        .load_data  (imem_wdata),
        .word_idx_o (word_idx),
        .instr_o    (instr_f)
    );

    tsc_decode #(.DATA_W(DATA_W)) u_decode (
        .instr (instr_f),
        .ctl   (ctl_d),
        .imm_o (imm_d)
    );

    tsc_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (!flush),
        .ra_a  (ctl_d.src_a),
        .ra_b  (ctl_d.src_b),
        .rd_a  (rs_val_d),
        .rd_b  (rt_val_d),
        .we    (wb_we),
        .wa    (wb_dst),
        .wd    (wb_val)
    );

    // Capture the decoded instruction and operands into the execute register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_ctl <= '0;
            ex_a   <= '0;
            ex_b   <= '0;
            ex_imm <= '0;
        end else begin
            ex_ctl <= ctl_d;
            ex_a   <= rs_val_d;
            ex_b   <= rt_val_d;
            ex_imm <= imm_d;
        end
    end

    // Bypass the write-back value into operands whose source matches.
    always_comb begin
        opnd_a = ex_a;
        opnd_b_fwd = ex_b;
        if (wb_we && (wb_dst != '0) && (wb_dst == ex_ctl.src_a)) begin
            opnd_a = wb_val;
        end
        if (wb_we && (wb_dst != '0) && (wb_dst == ex_ctl.src_b)) begin
            opnd_b_fwd = wb_val;
        end
        opnd_b = ex_ctl.use_imm ? ex_imm : opnd_b_fwd;
    end

    tsc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ex_ctl.op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (alu_y)
    );

    // Capture the ALU result into the write-back register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_we  <= 1'b0;
            wb_dst <= '0;
            wb_val <= '0;
        end else begin
            wb_we  <= ex_ctl.wr_en;
            wb_dst <= ex_ctl.dst;
            wb_val <= alu_y;
        end
    end

    assign pc_o      = {word_idx, 2'b00};
    assign wb_en_o   = wb_we;
    assign wb_addr_o = wb_dst;
    assign wb_data_o = wb_val;

    // R10
    flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ex_ctl.wr_en);

    // R9
    nop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_f == 32'd0) |=> !ex_ctl.wr_en);

    // R6
    wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ctl.wr_en |=> (wb_we && (wb_dst == $past(ex_ctl.dst))));

    // R8
    no_zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_dst != '0));

endmodule

// File: tb/tsc_core_test.sv
// Bench for tsc_core: a sequential reference model runs the same program,
// delays each commit by two cycles and is compared on every clock.
module tsc_core_test;

    localparam int DW    = 32;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int PW    = AW + 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flush;
    logic          imem_we;
    logic [AW-1:0] imem_waddr;
    logic [31:0]   imem_wdata;
    logic [PW-1:0] pc_o;
    logic          wb_en_o;
    logic [4:0]    wb_addr_o;
    logic [DW-1:0] wb_data_o;

    always #5 clk = ~clk;

    tsc_core #(.DATA_W(DW), .IMEM_DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .pc_o       (pc_o),
        .wb_en_o    (wb_en_o),
        .wb_addr_o  (wb_addr_o),
        .wb_data_o  (wb_data_o)
    );

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;
    bit done = 0;

    logic [31:0] prog [DEPTH];

    // Reference model state.
    logic [PW-1:0] m_pc;
    string         pc_tag;
    logic [31:0]   mr [32];
    logic [4:0]    prev_dst;
    bit            ex_en, wb_en;
    logic [4:0]    ex_a, wb_a;
    logic [31:0]   ex_d, wb_d;
    string         ex_tag, wb_tag;

    function automatic logic [31:0] rr(logic [5:0] fn, logic [4:0] s, logic [4:0] t, logic [4:0] d);
        return {6'h00, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] ri(logic [5:0] op, logic [4:0] s, logic [4:0] t, logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Sequentially execute one instruction on the model registers.
    task automatic model_exec(logic [31:0] ins);
        logic [5:0]  op, fn;
        logic [4:0]  s, t, d;
        logic [31:0] a, b, imm, res;
        bit en;
        string tag;
        op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; fn = ins[5:0];
        a = mr[s]; b = mr[t];
        imm = {{16{ins[15]}}, ins[15:0]};
        en = 0; res = 0; tag = "R9";
        if (op == 6'h00 && ins[10:6] == 5'd0) begin
            en = 1; tag = "R3";
            case (fn)
                6'h20: res = a + b;
                6'h22: res = a - b;
                6'h24: res = a & b;
                6'h25: res = a | b;
                6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5"; end
                default: begin en = 0; tag = "R9"; end
            endcase
        end else if (op != 6'h00) begin
            d = t; en = 1; tag = "R4";
            case (op)
                6'h08: res = a + imm;
                6'h0A: begin res = ($signed(a) < $signed(imm)) ? 32'd1 : 32'd0; tag = "R5"; end
                6'h0C: res = a & imm;
                6'h0D: res = a | imm;
                default: begin en = 0; tag = "R9"; end
            endcase
        end
        if (en && prev_dst != 0 && (s == prev_dst || (op == 6'h00 && t == prev_dst))) tag = "R7";
        if (en && d == 5'd0) begin en = 0; tag = "R8"; end
        if (en) mr[d] = res;
        prev_dst = en ? d : 5'd0;
        ex_en = en; ex_a = d; ex_d = res; ex_tag = tag;
    endtask

    // Advance the model on every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_pc = '0; pc_tag = "R1";
            for (int i = 0; i < 32; i++) mr[i] = '0;
            prev_dst = 0;
            ex_en = 0; ex_a = 0; ex_d = 0; ex_tag = "R1";
            wb_en = 0; wb_a = 0; wb_d = 0; wb_tag = "R1";
        end else begin
            wb_en = ex_en; wb_a = ex_a; wb_d = ex_d; wb_tag = ex_tag;
            if (flush) begin
                ex_en = 0; ex_tag = "R10"; pc_tag = "R10";
            end else begin
                model_exec(prog[m_pc[PW-1:2]]);
                m_pc = m_pc + PW'(4);
                pc_tag = "R2";
            end
        end
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(pc_tag, "pc", 64'(pc_o), 64'(m_pc));
            chk(wb_tag, "wb_en (R6)", 64'(wb_en_o), 64'(wb_en));
            if (wb_en) begin
                chk(wb_tag, "wb_addr", 64'(wb_addr_o), 64'(wb_a));
                chk(wb_tag, "wb_data", 64'(wb_data_o), 64'(wb_d));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) prog[i] = 32'd0;
        prog[0]  = ri(6'h08, 5'd0, 5'd1, 16'd5);        // addi r1 = 5
        prog[1]  = ri(6'h08, 5'd0, 5'd2, 16'hFFFD);     // addi r2 = -3
        prog[2]  = rr(6'h20, 5'd1, 5'd2, 5'd3);         // add r3, distance 1 and 2 (R7)
        prog[3]  = rr(6'h22, 5'd3, 5'd1, 5'd4);         // sub r4 = -3
        prog[4]  = rr(6'h2A, 5'd4, 5'd1, 5'd5);         // slt -3 < 5 -> 1 (R5)
        prog[5]  = rr(6'h2A, 5'd1, 5'd4, 5'd6);         // slt 5 < -3 -> 0
        prog[6]  = rr(6'h24, 5'd2, 5'd1, 5'd7);         // and
        prog[7]  = rr(6'h25, 5'd2, 5'd1, 5'd8);         // or
        prog[8]  = ri(6'h0C, 5'd2, 5'd9, 16'h00F0);     // andi
        prog[9]  = ri(6'h0D, 5'd1, 5'd10, 16'h8000);    // ori, sign-extended (R4)
        prog[10] = ri(6'h0A, 5'd4, 5'd11, 16'hFFFE);    // slti -3 < -2 -> 1
        prog[11] = ri(6'h0A, 5'd1, 5'd12, 16'hFFFE);    // slti 5 < -2 -> 0
        prog[12] = ri(6'h08, 5'd1, 5'd0, 16'd7);        // write r0 ignored (R8)
        prog[13] = rr(6'h20, 5'd0, 5'd1, 5'd13);        // r0 reads zero
        prog[14] = 32'd0;                               // no-op (R9)
        prog[15] = ri(6'h3F, 5'd1, 5'd14, 16'd9);       // undecoded opcode
        prog[16] = rr(6'h21, 5'd1, 5'd1, 5'd14);        // undecoded function
        prog[17] = rr(6'h20, 5'd14, 5'd1, 5'd15);       // r14 untouched
        prog[18] = {6'h00, 5'd1, 5'd1, 5'd18, 5'd3, 6'h20}; // nonzero [10:6]
        prog[19] = ri(6'h08, 5'd17, 5'd17, 16'd1);      // accumulate chain
        prog[20] = ri(6'h08, 5'd17, 5'd17, 16'd1);
        prog[21] = ri(6'h08, 5'd17, 5'd17, 16'd1);
        prog[22] = ri(6'h08, 5'd17, 5'd17, 16'd1);
        prog[23] = rr(6'h20, 5'd17, 5'd17, 5'd19);
        prog[24] = rr(6'h22, 5'd19, 5'd2, 5'd20);
        prog[25] = rr(6'h2A, 5'd2, 5'd0, 5'd21);
        prog[26] = rr(6'h20, 5'd18, 5'd15, 5'd22);

        rst_n = 1'b0; flush = 1'b0; imem_we = 1'b0; imem_waddr = '0; imem_wdata = '0;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        flush = 1'b1;                       // drain during reset has no effect (R1)
        repeat (2) @(negedge clk);
        flush = 1'b0;
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 600; cyc++) begin
            flush = (((cyc % 19) >= 6) && ((cyc % 19) <= 8)) || ((cyc % 13) == 2);
            @(negedge clk);
        end
        flush = 1'b0;
        rst_n = 1'b0;                       // mid-run reset (R1)
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule